// File: doc/BRIEF.md
# Codec Command Slot Interface

This block lets a host reach the control registers of an audio codec through two command slot registers. The host first writes the data slot, then writes the command slot. The command slot holds a read/write flag and a 7-bit codec register address, and writing it starts one codec transaction. A write drives the address and the data onto a codec register access port and pulses the write strobe once. A read samples the codec read data. It then returns two words in receive slot registers: the command word with its read flag cleared, and the data shifted into position.

A flag register reports whether each transmit slot is empty, whether each receive slot is busy, and whether it holds valid data. The host polls this register to pace its accesses. The slot registers are 20 bits wide. Address and data sit at fixed bit positions within them, which the codec side decodes.

Top module: `codec_cmd_slots`

## Requirements
- R1: After reset the flag word is 7'h07. The flag bits are: bit0 command slot empty, bit1 data slot empty, bit2 both slots empty, bit3 command receive busy, bit4 data receive busy, bit5 command receive valid, bit6 data receive valid. Both receive slots read as zero after reset.
- R2: A host write to register 1 (data slot) stores the value and clears flag bits 1 and 2. It starts no codec transaction.
- R3: A host write to register 0 (command slot) with bit 19 low is a codec write. In the next cycle the block drives the codec address from slot bits 18:12 and the write data from data-slot bits 19:4. It asserts the write strobe for exactly that one cycle.
- R4: A command slot write clears flag bits 0 and 2. One cycle after the transaction is issued, flag bits 0, 1 and 2 are set again.
- R5: A command slot write with bit 19 high is a codec read and never asserts the write strobe. On completion, receive register 2 holds the command word with bit 19 cleared, and receive register 3 holds the codec read data shifted left by 4.
- R6: Starting a read sets flag bits 3 and 4 for one cycle. Completion then clears them and sets flag bits 5 and 6.
- R7: A host read of register 3 clears flag bits 5 and 6. A host read of register 2 leaves them set.
- R8: Host reads of registers 0 to 4 return the command slot, data slot, receive slot 1, receive slot 2 and flag word in that order. Other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Host register write enable |
| reg_rd_en | input | 1 | Host register read enable (read side effects) |
| reg_addr | input | 3 | Host register index |
| reg_wdata | input | 20 | Host write data |
| reg_rdata | output | 20 | Host read data (combinational) |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec write data |
| cdc_we | output | 1 | Codec write strobe |
| cdc_rdata | input | 16 | Codec read data for cdc_addr |
| slot_flags | output | 7 | Slot flag word |

## Verification
Codec writes go to several addresses with distinct data words. Each pattern sets a different bit of the address and data fields, so a shifted or truncated field shows up as a wrong address or a wrong value at the codec port. Reads go both to written locations and to untouched ones. This separates a read that returns the stored value from one that returns the pre-loaded contents. Comparing the echoed command word against the written word catches a read flag that is not cleared, or address bits that are lost. Flags are sampled in the cycle a transaction is issued and in the cycle after it. This shows when busy, valid and empty change, and that only a read of the data receive slot clears the valid flags.

// File: rtl/codec_cmd_slots.sv
module codec_cmd_slots #(
  parameter int SLOT_W   = 20,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int RW_BIT   = 19,
  parameter int ADDR_LSB = 12,
  parameter int DATA_LSB = 4,
  parameter int FLAG_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [2:0]        reg_addr,
  input  logic [SLOT_W-1:0] reg_wdata,
  output logic [SLOT_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] cdc_addr,
  output logic [DATA_W-1:0] cdc_wdata,
  output logic              cdc_we,
  input  logic [DATA_W-1:0] cdc_rdata,
  output logic [FLAG_W-1:0] slot_flags
);
  localparam logic [2:0] A_CMD = 3'd0, A_DAT = 3'd1, A_RX1 = 3'd2, A_RX2 = 3'd3, A_FLG = 3'd4;
  localparam logic [SLOT_W-1:0] RW_MASK = SLOT_W'(1) << RW_BIT;

  logic [SLOT_W-1:0] cmd_q, dat_q, rx1_q, rx2_q;
  logic cmd_empty, dat_empty, both_empty;
  logic rx1_busy, rx2_busy, rx1_valid, rx2_valid;
  logic issue_q;

  wire wr_cmd  = reg_wr_en && reg_addr == A_CMD;
  wire wr_dat  = reg_wr_en && reg_addr == A_DAT;
  wire rd_rx2  = reg_rd_en && reg_addr == A_RX2;
  wire is_read = cmd_q[RW_BIT];
  wire rd_done = issue_q && is_read;

  assign cdc_addr  = cmd_q[ADDR_LSB +: ADDR_W];
  assign cdc_wdata = dat_q[DATA_LSB +: DATA_W];
  assign cdc_we    = issue_q && !is_read;

  assign slot_flags = FLAG_W'({rx2_valid, rx1_valid, rx2_busy, rx1_busy,
                               both_empty, dat_empty, cmd_empty});

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_DAT:   reg_rdata = dat_q;
      A_RX1:   reg_rdata = rx1_q;
      A_RX2:   reg_rdata = rx2_q;
      A_FLG:   reg_rdata = SLOT_W'(slot_flags);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; dat_q <= '0; rx1_q <= '0; rx2_q <= '0;
      cmd_empty <= 1'b1; dat_empty <= 1'b1; both_empty <= 1'b1;
      rx1_busy <= 1'b0; rx2_busy <= 1'b0;
      rx1_valid <= 1'b0; rx2_valid <= 1'b0;
      issue_q <= 1'b0;
    end else begin
      issue_q <= wr_cmd;
      if (issue_q) begin
        cmd_empty <= 1'b1; dat_empty <= 1'b1; both_empty <= 1'b1;
      end
      if (rd_done) begin
        rx1_q     <= cmd_q & ~RW_MASK;
        rx2_q     <= SLOT_W'(cdc_rdata) << DATA_LSB;
        rx1_busy  <= 1'b0; rx2_busy  <= 1'b0;
        rx1_valid <= 1'b1; rx2_valid <= 1'b1;
      end else if (rd_rx2) begin
        rx1_valid <= 1'b0; rx2_valid <= 1'b0;
      end
      if (wr_cmd) begin
        cmd_q      <= reg_wdata;
        cmd_empty  <= 1'b0;
        both_empty <= 1'b0;
        if (reg_wdata[RW_BIT]) begin
          rx1_busy <= 1'b1; rx2_busy <= 1'b1;
        end
      end
      if (wr_dat) begin
        dat_q      <= reg_wdata;
        dat_empty  <= 1'b0;
        both_empty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/codec_cmd_slots_chk.sv
module codec_cmd_slots_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic        reg_rd_en,
  input logic [2:0]  reg_addr,
  input logic        cdc_we,
  input logic [6:0]  slot_flags
);
  p_we_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_we |=> !cdc_we);

  p_cmd_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 3'd0) |=> (!slot_flags[0] && !slot_flags[2]));

  p_empty_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_we && !reg_wr_en) |=> (slot_flags[2:0] == 3'b111));

  p_read_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_flags[3] |-> !cdc_we);

  p_busy_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_flags[3] && !reg_wr_en) |=> (!slot_flags[3] && !slot_flags[4] && slot_flags[5] && slot_flags[6]));

  p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == 3'd3 && !slot_flags[3]) |=> (!slot_flags[5] && !slot_flags[6]));
endmodule

bind codec_cmd_slots codec_cmd_slots_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .cdc_we(cdc_we), .slot_flags(slot_flags)
);

// File: tb/tb_codec_cmd_slots.sv
module tb_codec_cmd_slots;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic [6:0]  cdc_addr;
  logic [15:0] cdc_wdata;
  logic        cdc_we;
  logic [15:0] cdc_rdata;
  logic [6:0]  slot_flags;

  int vectors = 0, errors = 0;
  logic [15:0] codec_mem [128];
  logic [15:0] shadow    [128];
  logic [22:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_cmd_slots dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cdc_addr(cdc_addr), .cdc_wdata(cdc_wdata), .cdc_we(cdc_we),
    .cdc_rdata(cdc_rdata), .slot_flags(slot_flags)
  );

  assign cdc_rdata = codec_mem[cdc_addr];
  always @(posedge clk) if (cdc_we) codec_mem[cdc_addr] <= cdc_wdata;

  function automatic logic [15:0] init_word(int i);
    return 16'hA000 ^ 16'(i * 16'h0101);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cdc_we) begin
      if (exp_q.size() == 0) check("R5 unexpected strobe", {9'b0, cdc_addr, cdc_wdata}, 32'hFFFFFFFF);
      else check("R3 codec write", {9'b0, cdc_addr, cdc_wdata}, {9'b0, exp_q.pop_front()});
    end
  end

  task automatic reg_write(logic [2:0] a, logic [19:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [19:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic codec_write(logic [6:0] a, logic [15:0] d);
    reg_write(3'd1, {d, 4'h0});
    exp_q.push_back({a, d});
    shadow[a] = d;
    reg_write(3'd0, {1'b0, a, 12'h000});
    check("R4 cmd empty cleared", 32'(slot_flags[2:0]), 32'h0);
    @(negedge clk);
    check("R4 empties set", 32'(slot_flags), 32'h07);
  endtask

  task automatic codec_read(logic [6:0] a, logic [11:0] low);
    logic [19:0] w, r;
    w = {1'b1, a, low};
    reg_write(3'd0, w);
    check("R6 busy set", 32'(slot_flags[6:3]), 32'h3);
    @(negedge clk);
    check("R6 valid set busy clear", 32'(slot_flags[6:3]), 32'hC);
    reg_read(3'd2, r);
    check("R5 echo word", 32'(r), 32'(w & 20'h7FFFF));
    check("R7 rx1 read keeps valid", 32'(slot_flags[6:5]), 32'h3);
    reg_read(3'd3, r);
    check("R5 read data", 32'(r), 32'({shadow[a], 4'h0}));
    check("R7 rx2 read clears valid", 32'(slot_flags[6:5]), 32'h0);
  endtask

  initial begin
    logic [19:0] r;
    for (int i = 0; i < 128; i++) begin
      codec_mem[i] = init_word(i);
      shadow[i]    = init_word(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset flags", 32'(slot_flags), 32'h07);
    reg_read(3'd2, r); check("R1 rx1 reset", 32'(r), 32'h0);
    reg_read(3'd3, r); check("R1 rx2 reset", 32'(r), 32'h0);
    reg_read(3'd5, r); check("R8 unmapped", 32'(r), 32'h0);

    reg_write(3'd1, 20'h5A5A3);
    check("R2 data slot flags", 32'(slot_flags), 32'h01);
    reg_read(3'd1, r); check("R8 data slot readback", 32'(r), 32'h5A5A3);
    @(negedge clk);
    check("R2 no strobe", 32'(exp_q.size()), 32'h0);

    codec_write(7'h15, 16'h1234);
    codec_write(7'h40, 16'h8001);
    codec_write(7'h01, 16'hFFFF);
    codec_write(7'h7F, 16'h00F0);
    reg_read(3'd0, r); check("R8 cmd readback", 32'(r), 32'h7F000);
    reg_read(3'd4, r); check("R8 flag readback", 32'(r), 32'h07);

    codec_read(7'h15, 12'hABC);
    codec_read(7'h7F, 12'h001);
    codec_read(7'h22, 12'h000);
    codec_read(7'h40, 12'hFFF);
    check("R3 all writes seen", 32'(exp_q.size()), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule